// File: doc/BRIEF.md
# SPI Flash Page-Program Sequencer

This block is the host-side engine that writes to a serial NOR flash through a four-wire SPI master port running in mode 0. Software loads up to one page of data into a small internal byte buffer, then issues a single request: program a page, erase a 64 KiB sector, or erase the whole array. The sequencer first checks the request. If it is legal, it sends a write-enable frame on its own, and then the modifying command frame. After that it keeps reading the status register until the busy flag drops, and ends with a one-cycle `done` or `err` pulse.

Each frame is bracketed by chip select. Between two frames, chip select stays high for a configurable minimum number of clocks. Polling is bounded: if the flash still reports busy after a set number of status reads, the request ends with an error. This stops a dead or missing part from hanging the host. A page program is limited to a single 256-byte page. A request that would wrap inside the page is rejected before any bus activity.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done` and `err` are 0.
- R2: A request with `req_op` = 3 (reserved), or a program request (`req_op` = 0) with length 0 or above 256, produces an `err` pulse on the cycle after it is sampled. `busy` stays 0 and no chip-select frame is issued.
- R3: A program request whose page offset (`req_addr[7:0]`) plus length exceeds 256 is rejected in the same way as in R2. An offset plus length of exactly 256 is accepted.
- R4: Every accepted request starts with a one-byte frame carrying 06h, closed by chip select before the next frame.
- R5: A program request (`req_op` = 0) sends one frame: 02h, then `req_addr[23:16]`, `req_addr[15:8]` and `req_addr[7:0]` (upper bits sent unchanged), then buffer bytes 0 to length-1. Every byte goes out most significant bit first.
- R6: A sector erase (`req_op` = 1) sends D8h followed by the three address bytes. A bulk erase (`req_op` = 2) sends only C7h.
- R7: Between consecutive frames of one request, `spi_cs_n` stays high for at least `CS_GAP` clock cycles.
- R8: After the command frame, the block sends status frames (05h plus one read byte). It repeats them while bit 0 of the returned status is 1, and pulses `done` after the first read with bit 0 equal to 0.
- R9: If bit 0 is still 1 after `MAX_POLLS` status reads, the block pulses `err` instead of `done` and sends no further frames.
- R10: SPI mode 0: `spi_sck` idles low, toggles only while `spi_cs_n` is low, and `spi_mosi` changes only while `spi_sck` is low.
- R11: `busy` is 1 from acceptance until the cycle in which `done` or `err` rises. Requests presented while `busy` is 1 are ignored.
- R12: `done` and `err` are single-cycle pulses and are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_we | input | 1 | Page buffer write strobe |
| buf_waddr | input | 8 | Page buffer byte index |
| buf_wdata | input | 8 | Page buffer write data |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_op | input | 2 | 0 program, 1 sector erase, 2 bulk erase, 3 reserved |
| req_addr | input | 24 | Flash start address |
| req_len | input | 9 | Program byte count |
| busy | output | 1 | Request in progress |
| done | output | 1 | Success pulse |
| err | output | 1 | Rejection or poll-limit pulse |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to flash |
| spi_miso | input | 1 | SPI data from flash |

## Verification
A rejected request must show `err` exactly one cycle after the edge that samples it. The bench drives the request after a falling edge and checks `err` and `busy` at the very next falling edge. It then checks the following falling edge to confirm the pulse has gone. An accepted request ends only after a number of cycles that depends on the SCK divider, the chip-select gap and the number of status polls, so the bench does not predict that count. It waits for `done` or `err` at falling edges, and checks `busy` on every cycle before the pulse. A flash model in the bench decodes the serial frames from the pins, answers status reads with a programmed number of busy replies, and logs every byte. The frame contents, the frame count and the shortest chip-select gap are compared with values computed from the request, after a settle interval that would expose any stray frame.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_BERASE = 2'd2,
    OP_RSVD   = 2'd3
  } req_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    FR_WREN = 2'd0,
    FR_CMD  = 2'd1,
    FR_STAT = 2'd2
  } frame_kind_e;

  localparam logic [7:0] CMD_WREN   = 8'h06;
  localparam logic [7:0] CMD_PROG   = 8'h02;
  localparam logic [7:0] CMD_RDSR   = 8'h05;
  localparam logic [7:0] CMD_SERASE = 8'hD8;
  localparam logic [7:0] CMD_BERASE = 8'hC7;

  function automatic logic [7:0] opcode_of(req_op_e op);
    case (op)
      OP_PROG:   opcode_of = CMD_PROG;
      OP_SERASE: opcode_of = CMD_SERASE;
      default:   opcode_of = CMD_BERASE;
    endcase
  endfunction

endpackage

// File: rtl/flash_page_buf.sv
module flash_page_buf #(
  parameter int PAGE_BYTES = 256
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [$clog2(PAGE_BYTES)-1:0] waddr,
  input  logic [7:0]                    wdata,
  input  logic [$clog2(PAGE_BYTES)-1:0] raddr,
  output logic [7:0]                    rdata
);
  logic [7:0] mem [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/flash_req_check.sv
module flash_req_check
  import flash_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 256
) (
  input  req_op_e                       op,
  input  logic [$clog2(PAGE_BYTES)-1:0] ofs,
  input  logic [$clog2(PAGE_BYTES):0]   len,
  output logic                          bad
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int LEN_W = OFS_W + 1;

  logic [LEN_W:0] end_pos;
  logic           len_bad;
  logic           wrap_bad;

  always_comb begin
    end_pos  = {2'b00, ofs} + {1'b0, len};
    len_bad  = (len == '0) || (len > LEN_W'(PAGE_BYTES));
    wrap_bad = end_pos > (LEN_W + 1)'(PAGE_BYTES);
    case (op)
      OP_RSVD: bad = 1'b1;
      OP_PROG: bad = len_bad || wrap_bad;
      default: bad = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_spi_shifter.sv
module flash_spi_shifter #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] din,
  input  logic       miso,
  output logic       done,
  output logic [7:0] dout,
  output logic       sck,
  output logic       mosi
);
  localparam int CNT_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic             act_q, act_d;
  logic             sck_q, sck_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       tx_q, tx_d;
  logic [7:0]       rx_q, rx_d;
  logic             half_end;

  assign half_end = (cnt_q == CNT_W'(SCK_HALF - 1));

  always_comb begin
    act_d  = act_q;
    sck_d  = sck_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (!act_q) begin
      if (start) begin
        act_d = 1'b1;
        tx_d  = din;
        cnt_d = '0;
        bit_d = '0;
        sck_d = 1'b0;
      end
    end else if (half_end) begin
      cnt_d = '0;
      if (!sck_q) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[6:0], miso};
      end else begin
        sck_d = 1'b0;
        if (bit_q == 3'd7) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          tx_d  = {tx_q[6:0], 1'b0};
          bit_d = bit_q + 3'd1;
        end
      end
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      act_q  <= act_d;
      sck_q  <= sck_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign done = done_q;
  assign dout = rx_q;
  assign sck  = sck_q;
  assign mosi = tx_q[7];

  // R10
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> $stable(tx_q[7]));
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int ADDR_BYTES = 3,
  parameter int SCK_HALF   = 2,
  parameter int CS_GAP     = 4,
  parameter int MAX_POLLS  = 4096
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          buf_we,
  input  logic [$clog2(PAGE_BYTES)-1:0] buf_waddr,
  input  logic [7:0]                    buf_wdata,
  input  logic                          req_valid,
  input  logic [1:0]                    req_op,
  input  logic [ADDR_BYTES*8-1:0]       req_addr,
  input  logic [$clog2(PAGE_BYTES):0]   req_len,
  output logic                          busy,
  output logic                          done,
  output logic                          err,
  output logic                          spi_sck,
  output logic                          spi_cs_n,
  output logic                          spi_mosi,
  input  logic                          spi_miso
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int LEN_W  = OFS_W + 1;
  localparam int AW     = ADDR_BYTES * 8;
  localparam int FL_W   = LEN_W + 1;
  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam int GAP_W  = $clog2(CS_GAP + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  seq_state_e        state_q, state_d;
  frame_kind_e       kind_q, kind_d;
  req_op_e           op_q, op_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [FL_W-1:0]   fcnt_q, fcnt_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [POLL_W-1:0] poll_q, poll_d;
  logic              wip_q, wip_d;
  logic              cs_n_q, cs_n_d;
  logic              start_q, start_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  logic              req_bad;
  logic              sh_done;
  logic [7:0]        sh_rx;
  logic [7:0]        tx_byte;
  logic [7:0]        buf_rd;
  logic [OFS_W-1:0]  buf_raddr;
  logic [FL_W-1:0]   flen;
  logic              last_byte;
  logic              gap_end;

  flash_req_check #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
    .op  (req_op_e'(req_op)),
    .ofs (req_addr[OFS_W-1:0]),
    .len (req_len),
    .bad (req_bad)
  );

  flash_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (buf_raddr),
    .rdata (buf_rd)
  );

  flash_spi_shifter #(.SCK_HALF(SCK_HALF)) u_sh (
    .clk   (clk),
    .rst_n (rst_ns),
    .start (start_q),
    .din   (tx_byte),
    .miso  (spi_miso),
    .done  (sh_done),
    .dout  (sh_rx),
    .sck   (spi_sck),
    .mosi  (spi_mosi)
  );

  // frame length and byte selection
  assign buf_raddr = OFS_W'(fcnt_q - FL_W'(ADDR_BYTES + 1));

  always_comb begin
    case (kind_q)
      FR_WREN: flen = FL_W'(1);
      FR_STAT: flen = FL_W'(2);
      default: begin
        case (op_q)
          OP_PROG:   flen = FL_W'(len_q) + FL_W'(ADDR_BYTES + 1);
          OP_SERASE: flen = FL_W'(ADDR_BYTES + 1);
          default:   flen = FL_W'(1);
        endcase
      end
    endcase
  end

  always_comb begin
    case (kind_q)
      FR_WREN: tx_byte = CMD_WREN;
      FR_STAT: tx_byte = (fcnt_q == '0) ? CMD_RDSR : 8'h00;
      default: begin
        if (fcnt_q == '0)
          tx_byte = opcode_of(op_q);
        else if (fcnt_q <= FL_W'(ADDR_BYTES))
          tx_byte = 8'(addr_q >> (8 * (ADDR_BYTES - int'(fcnt_q))));
        else
          tx_byte = buf_rd;
      end
    endcase
  end

  assign last_byte = (fcnt_q == flen - FL_W'(1));
  assign gap_end   = (gap_q == GAP_W'(CS_GAP - 1));

  // next-state logic
  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    op_d    = op_q;
    addr_d  = addr_q;
    len_d   = len_q;
    fcnt_d  = fcnt_q;
    gap_d   = gap_q;
    poll_d  = poll_q;
    wip_d   = wip_q;
    cs_n_d  = cs_n_q;
    start_d = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_bad) begin
            err_d = 1'b1;
          end else begin
            op_d    = req_op_e'(req_op);
            addr_d  = req_addr;
            len_d   = req_len;
            kind_d  = FR_WREN;
            poll_d  = '0;
            fcnt_d  = '0;
            cs_n_d  = 1'b0;
            start_d = 1'b1;
            state_d = ST_XFER;
          end
        end
      end
      ST_XFER: begin
        if (sh_done) begin
          if (last_byte) begin
            cs_n_d  = 1'b1;
            gap_d   = '0;
            state_d = ST_GAP;
            if (kind_q == FR_STAT) begin
              wip_d  = sh_rx[0];
              poll_d = poll_q + POLL_W'(1);
            end
          end else begin
            fcnt_d  = fcnt_q + FL_W'(1);
            start_d = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (!gap_end) begin
          gap_d = gap_q + GAP_W'(1);
        end else if (kind_q == FR_STAT && !wip_q) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (kind_q == FR_STAT && poll_q >= POLL_W'(MAX_POLLS)) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          kind_d  = (kind_q == FR_WREN) ? FR_CMD : FR_STAT;
          fcnt_d  = '0;
          cs_n_d  = 1'b0;
          start_d = 1'b1;
          state_d = ST_XFER;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      kind_q  <= FR_WREN;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      len_q   <= '0;
      fcnt_q  <= '0;
      gap_q   <= '0;
      poll_q  <= '0;
      wip_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      len_q   <= len_d;
      fcnt_q  <= fcnt_d;
      gap_q   <= gap_d;
      poll_q  <= poll_d;
      wip_q   <= wip_d;
      cs_n_q  <= cs_n_d;
      start_q <= start_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign spi_cs_n = cs_n_q;

  // chip-select high-time monitor for the gap check
  logic [15:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)          hi_run_q <= '1;
    else if (!spi_cs_n)   hi_run_q <= '0;
    else if (~&hi_run_q)  hi_run_q <= hi_run_q + 16'd1;
  end

  // R7
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(spi_cs_n) |-> (hi_run_q >= 16'(CS_GAP)));

  // R10
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    spi_cs_n |-> !spi_sck);

  // R11
  cs_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !busy |-> spi_cs_n);

  // R12
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !(done && err));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done);

  // R2
  bad_req_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && !busy && req_bad) |=> (err && !busy));
endmodule

// File: tb/sim_flash_prog_seq.sv
`timescale 1ns/1ps
module sim_flash_prog_seq;
  localparam int CS_GAP    = 3;
  localparam int MAX_POLLS = 6;
  localparam int NV        = 13;

  logic        clk;
  logic        rst_n;
  logic        buf_we;
  logic [7:0]  buf_waddr;
  logic [7:0]  buf_wdata;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [23:0] req_addr;
  logic [8:0]  req_len;
  logic        busy, done, err;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

  flash_prog_seq #(
    .PAGE_BYTES(256), .ADDR_BYTES(3), .SCK_HALF(2),
    .CS_GAP(CS_GAP), .MAX_POLLS(MAX_POLLS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_waddr(buf_waddr),
    .buf_wdata(buf_wdata), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done),
    .err(err), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  // flash model: decodes frames, answers status reads
  logic [7:0] mlog [0:4095];
  int         fs [0:63];
  int         fl [0:63];
  int         fcount, lptr, m_byte, busy_left, cfg_busy;
  logic [2:0] m_bit;
  logic [7:0] m_sh, m_op;
  logic       wel;
  bit         mon_on = 1'b0;
  logic [7:0] mstat;

  assign mstat    = {6'b0, wel, (busy_left > 0)};
  assign spi_miso = (!spi_cs_n && m_byte == 1 && m_op == 8'h05) ? mstat[3'd7 - m_bit] : 1'b0;

  always @(negedge spi_cs_n) if (mon_on) begin
    m_bit  = 3'd0;
    m_byte = 0;
    if (fcount < 64) fs[fcount] = lptr;
  end

  always @(posedge spi_sck) if (mon_on && !spi_cs_n) begin
    m_sh  = {m_sh[6:0], spi_mosi};
    m_bit = m_bit + 3'd1;
    if (m_bit == 3'd0) begin
      if (m_byte == 0) m_op = m_sh;
      if (lptr < 4096) begin
        mlog[lptr] = m_sh;
        lptr++;
      end
      m_byte++;
    end
  end

  always @(posedge spi_cs_n) if (mon_on) begin
    if (fcount < 64) fl[fcount] = m_byte;
    if (m_op == 8'h05 && m_byte >= 2 && busy_left > 0) busy_left--;
    if (m_op == 8'h06) wel = 1'b1;
    if (m_op == 8'h02 || m_op == 8'hD8 || m_op == 8'hC7) begin
      busy_left = cfg_busy;
      wel       = 1'b0;
    end
    fcount++;
  end

  int run = 0;
  int min_gap;
  always @(negedge clk) if (mon_on) begin
    if (spi_cs_n) run++;
    else begin
      if (run > 0 && fcount > 0 && run < min_gap) min_gap = run;
      run = 0;
    end
  end

  // op, addr, len, busy replies, request invalid
  localparam logic [43:0] VEC [NV] = '{
    {2'd0, 24'h123400, 9'd256, 8'd3,  1'b0},
    {2'd0, 24'hE567F0, 9'd16,  8'd0,  1'b0},
    {2'd0, 24'h000080, 9'd1,   8'd2,  1'b0},
    {2'd0, 24'h0000FF, 9'd1,   8'd1,  1'b0},
    {2'd0, 24'h000001, 9'd256, 8'd0,  1'b1},
    {2'd0, 24'h000000, 9'd0,   8'd0,  1'b1},
    {2'd0, 24'h000000, 9'd257, 8'd0,  1'b1},
    {2'd0, 24'h0000F0, 9'd17,  8'd0,  1'b1},
    {2'd1, 24'h1A0000, 9'd0,   8'd4,  1'b0},
    {2'd2, 24'h000000, 9'd0,   8'd5,  1'b0},
    {2'd2, 24'h000000, 9'd0,   8'd6,  1'b0},
    {2'd3, 24'h000000, 9'd1,   8'd0,  1'b1},
    {2'd1, 24'h050000, 9'd0,   8'd10, 1'b0}
  };

  task automatic run_req(input logic [1:0] op, input logic [23:0] addr,
                         input int len, input int nbusy, input bit bad,
                         input bit inject);
    int  t = 0;
    int  busy_low = 0;
    int  nstat;
    int  exp_frames;
    bit  exp_err;
    int  f1len;
    fcount    = 0;
    lptr      = 0;
    cfg_busy  = nbusy;
    busy_left = 0;
    wel       = 1'b0;
    min_gap   = 1000000;
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = addr;
    req_len   = 9'(len);
    @(negedge clk);
    req_valid = 1'b0;
    while (!(done || err) && t < 40000) begin
      if (!busy) busy_low++;
      @(negedge clk);
      t++;
      if (inject && t == 50) begin
        req_valid = 1'b1;
        req_op    = 2'd0;
        req_addr  = 24'h000000;
        req_len   = 9'd4;
      end
      if (inject && t == 52) req_valid = 1'b0;
    end
    nstat      = bad ? 0 : ((nbusy + 1 > MAX_POLLS) ? MAX_POLLS : nbusy + 1);
    exp_err    = bad || (nbusy + 1 > MAX_POLLS);
    exp_frames = bad ? 0 : 2 + nstat;
    chk(err == exp_err && done == !exp_err, "R8 R9 R2 R3 outcome", int'({done, err}),
        int'({!exp_err, exp_err}));
    if (bad) chk(t == 0 && !busy, "R2 R3 err latency", t, 0);
    else     chk(busy_low == 0 && !busy, "R11 busy span", busy_low, 0);
    @(negedge clk);
    chk(!done && !err, "R12 single-cycle pulse", int'({done, err}), 0);
    repeat (200) @(negedge clk);
    chk(fcount == exp_frames, "R8 R9 R11 frame count", fcount, exp_frames);
    if (!bad && fcount == exp_frames) begin
      chk(fl[0] == 1 && mlog[fs[0]] == 8'h06, "R4 enable frame", int'(mlog[fs[0]]), 6);
      f1len = (op == 2'd0) ? len + 4 : ((op == 2'd1) ? 4 : 1);
      chk(fl[1] == f1len, "R5 R6 command length", fl[1], f1len);
      for (int k = 0; k < f1len; k++) begin
        logic [7:0] e;
        if (k == 0) e = (op == 2'd0) ? 8'h02 : ((op == 2'd1) ? 8'hD8 : 8'hC7);
        else if (k <= 3) e = 8'(addr >> (8 * (3 - k)));
        else e = pat(k - 4);
        if (mlog[fs[1] + k] != e)
          chk(1'b0, "R5 R6 command byte", int'(mlog[fs[1] + k]), int'(e));
      end
      chk(1'b1, "R5 R6 command bytes", 0, 0);
      for (int s = 2; s < fcount; s++)
        chk(fl[s] == 2 && mlog[fs[s]] == 8'h05, "R8 status frame", int'(mlog[fs[s]]), 5);
      chk(min_gap >= CS_GAP, "R7 chip-select gap", min_gap, CS_GAP);
    end
    chk(spi_cs_n && !spi_sck, "R10 idle bus", int'({spi_cs_n, spi_sck}), 2);
  endtask

  initial begin
    rst_n     = 1'b0;
    buf_we    = 1'b0;
    buf_waddr = '0;
    buf_wdata = '0;
    req_valid = 1'b0;
    req_op    = '0;
    req_addr  = '0;
    req_len   = '0;
    fcount    = 0;
    lptr      = 0;
    m_byte    = 0;
    m_bit     = 3'd0;
    m_op      = 8'h00;
    m_sh      = 8'h00;
    busy_left = 0;
    cfg_busy  = 0;
    wel       = 1'b0;
    min_gap   = 1000000;
    repeat (4) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1 bus reset", int'({spi_cs_n, spi_sck}), 2);
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 status reset",
        int'({busy, done, err}), 0);
    rst_n  = 1'b1;
    mon_on = 1'b1;
    repeat (4) @(negedge clk);
    chk(spi_cs_n && !spi_sck && !busy, "R1 R10 idle after reset", int'({spi_cs_n, spi_sck, busy}), 4);
    for (int i = 0; i < 256; i++) begin
      buf_we    = 1'b1;
      buf_waddr = 8'(i);
      buf_wdata = pat(i);
      @(negedge clk);
    end
    buf_we = 1'b0;

    for (int v = 0; v < NV; v++)
      run_req(VEC[v][43:42], VEC[v][41:18], int'(VEC[v][17:9]),
              int'(VEC[v][8:1]), VEC[v][0], 1'b0);

    // R11: a request arriving mid-operation is dropped
    run_req(2'd1, 24'h0F0000, 0, 2, 1'b0, 1'b1);
    // R3: exact page fill from a nonzero offset
    run_req(2'd0, 24'h000010, 240, 0, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule